// File: doc/BRIEF.md
# Signed Power-of-Two Divider with Round-Toward-Zero

This block divides a signed two's-complement dividend by 2 raised to a shift amount, and truncates the quotient toward zero the way signed integer division does. It uses no divider circuit. The dividend is split into a sign flag and an unsigned magnitude. The magnitude is shifted right logically in a staged barrel shifter, and the sign is then put back by a conditional negation. A plain arithmetic right shift rounds negative values toward minus infinity, so it is not used.

The quotient is available combinationally on `q_now` in the same cycle as the operands. A small registered wrapper latches that quotient when `in_valid` is high, for a pipeline or a bench that wants a clocked result. The wrapper has two states:
- **ST_EMPTY**: no result is held.
- **ST_LOADED**: `quotient` holds the last captured result.

The transitions are:
- **T_CAPTURE**: from either state to ST_LOADED when `in_valid` is 1.
- **T_DRAIN**: from ST_LOADED to ST_EMPTY when `in_valid` is 0.
- **T_WAIT**: ST_EMPTY stays in ST_EMPTY when `in_valid` is 0.

Reset forces ST_EMPTY.

Shift amounts from 0 to WIDTH-2 are supported.

Top module: `pow2div_top`

## Requirements
- R1: For every dividend and every shift amount y from 0 to 30, `q_now` equals the dividend divided by 2^y, truncated toward zero, in the same cycle.
- R2: For a non-negative dividend, `q_now` equals the dividend shifted right logically by y.
- R3: A negative dividend rounds toward zero, not toward minus infinity. For example, -7 with y=1 gives -3 (0xFFFFFFFD), and -3 with y=2 gives 0.
- R4: The most negative dividend, 0x80000000, gives -2^(31-y) for every y from 0 to 30.
- R5: With y=0, `q_now` equals the dividend unchanged.
- R6: The quotient never has the opposite sign to the dividend. A non-negative dividend gives a result of 0 or more, and a negative dividend gives a result of 0 or less.
- R7: When `in_valid` is 1 at a rising edge, after that edge `out_valid` is 1 and `quotient` holds the value `q_now` had at the edge (transition T_CAPTURE).
- R8: When `in_valid` is 0 at a rising edge, after that edge `out_valid` is 0 and `quotient` keeps its previous value (transitions T_DRAIN and T_WAIT).
- R9: While `rst_n` is 0, the wrapper is in ST_EMPTY, `out_valid` is 0 and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered wrapper |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the registered result |
| dividend | input | 32 | Signed two's-complement dividend |
| shamt | input | 5 | Power of two to divide by (0 to 30) |
| q_now | output | 32 | Combinational truncated quotient |
| out_valid | output | 1 | Registered result is held (state ST_LOADED) |
| quotient | output | 32 | Registered truncated quotient |

## Verification
The bench builds the block with its defaults, WIDTH=32 and SHIFT_W=5. This lets it sweep every legal shift amount from 0 to 30 against a 64-bit reference division. The sweep covers 0, 1, -1, the most positive value and the most negative value, where negation overflows in 32 bits. Hand-picked rounding cases with negative dividends, random dividends at random shifts, and capture, hold and drain sequences of the wrapper's two states complete the coverage.

// File: rtl/pow2div_pkg.sv
package pow2div_pkg;

    // Wrapper state: whether a captured quotient is being held.
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } hold_state_e;

endpackage

// File: rtl/pow2div_mag.sv
// Splits a two's-complement value into sign flag and unsigned magnitude.
// The magnitude is WIDTH bits wide, so the most negative value maps to
// 2^(WIDTH-1) without overflow.
module pow2div_mag #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             neg_o,
    output logic [WIDTH-1:0] mag_o
);

    always_comb begin
        neg_o = value_i[WIDTH-1];
        if (neg_o) begin
            mag_o = (~value_i) + WIDTH'(1);
        end else begin
            mag_o = value_i;
        end
    end

endmodule

// File: rtl/pow2div_shift.sv
// Logarithmic logical right shifter; one stage per shift-amount bit.
module pow2div_shift #(
    parameter int WIDTH   = 32,
    parameter int SHIFT_W = 5
) (
    input  logic [WIDTH-1:0]   mag_i,
    input  logic [SHIFT_W-1:0] amt_i,
    output logic [WIDTH-1:0]   res_o
);

    logic [WIDTH-1:0] stage [SHIFT_W+1];

    assign stage[0] = mag_i;

    for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k] ? (stage[k] >> STEP) : stage[k];
    end

    assign res_o = stage[SHIFT_W];

endmodule

// File: rtl/pow2div_restore.sv
// Re-applies the dividend's sign to the shifted magnitude.
module pow2div_restore #(
    parameter int WIDTH = 32
) (
    input  logic             neg_i,
    input  logic [WIDTH-1:0] mag_i,
    output logic [WIDTH-1:0] q_o
);

    always_comb begin
        if (neg_i) begin
            q_o = (~mag_i) + WIDTH'(1);
        end else begin
            q_o = mag_i;
        end
    end

endmodule

// File: rtl/pow2div_top.sv
module pow2div_top #(
    parameter int WIDTH   = 32,
    parameter int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   dividend,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [WIDTH-1:0]   q_now,
    output logic               out_valid,
    output logic [WIDTH-1:0]   quotient
);

    import pow2div_pkg::*;

    logic             sign_neg;
    logic [WIDTH-1:0] abs_val;
    logic [WIDTH-1:0] abs_shifted;

    hold_state_e state_q;
    hold_state_e state_d;

    pow2div_mag #(.WIDTH(WIDTH)) u_mag (
        .value_i (dividend),
        .neg_o   (sign_neg),
        .mag_o   (abs_val)
    );

    pow2div_shift #(.WIDTH(WIDTH), .SHIFT_W(SHIFT_W)) u_shift (
        .mag_i (abs_val),
        .amt_i (shamt),
        .res_o (abs_shifted)
    );

    pow2div_restore #(.WIDTH(WIDTH)) u_restore (
        .neg_i (sign_neg),
        .mag_i (abs_shifted),
        .q_o   (q_now)
    );

    // Next-state logic: T_CAPTURE, T_DRAIN, T_WAIT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captures on T_CAPTURE, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient <= '0;
        end else if (in_valid) begin
            quotient <= q_now;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

endmodule

// File: rtl/pow2div_chk.sv
module pow2div_chk #(
    parameter int WIDTH   = 32,
    parameter int SHIFT_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [WIDTH-1:0]   dividend,
    input logic [SHIFT_W-1:0] shamt,
    input logic [WIDTH-1:0]   q_now,
    input logic               out_valid,
    input logic [WIDTH-1:0]   quotient
);

    localparam logic [WIDTH-1:0] MIN_V = {1'b1, {(WIDTH-1){1'b0}}};

    AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (shamt == '0) |-> (q_now == dividend)); // R5

    AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !dividend[WIDTH-1] |-> !q_now[WIDTH-1]); // R6

    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        dividend[WIDTH-1] |-> (q_now[WIDTH-1] || (q_now == '0))); // R6

    AST_MIN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dividend == MIN_V) && (shamt != '1)) |-> (q_now == WIDTH'($signed(MIN_V) >>> shamt))); // R4

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && (quotient == $past(q_now)))); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(quotient))); // R8

endmodule

bind pow2div_top pow2div_chk #(.WIDTH(WIDTH), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/sim_pow2div_top.sv
module sim_pow2div_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] x;
        logic [4:0]  y;
        logic [31:0] q;
    } vec_t;

    // Hand-computed rounding and corner vectors.
    localparam vec_t VECS [14] = '{
        '{32'hFFFF_FFF9, 5'd1,  32'hFFFF_FFFD},  // -7/2   = -3
        '{32'h0000_0007, 5'd1,  32'h0000_0003},  //  7/2   =  3
        '{32'hFFFF_FFFF, 5'd5,  32'h0000_0000},  // -1/32  =  0
        '{32'hFFFF_FFF8, 5'd3,  32'hFFFF_FFFF},  // -8/8   = -1
        '{32'hFFFF_FFF7, 5'd3,  32'hFFFF_FFFF},  // -9/8   = -1
        '{32'hFFFF_FF9C, 5'd3,  32'hFFFF_FFF4},  // -100/8 = -12
        '{32'h8000_0000, 5'd30, 32'hFFFF_FFFE},  // min/2^30 = -2
        '{32'h7FFF_FFFF, 5'd30, 32'h0000_0001},  // max/2^30 = 1
        '{32'h8000_0000, 5'd0,  32'h8000_0000},  // min/1
        '{32'h8000_0000, 5'd1,  32'hC000_0000},  // min/2
        '{32'h0000_0064, 5'd0,  32'h0000_0064},  // 100/1
        '{32'hFFFF_FFFB, 5'd2,  32'hFFFF_FFFF},  // -5/4 = -1
        '{32'hFFFF_FFFD, 5'd2,  32'h0000_0000},  // -3/4 = 0
        '{32'h0000_0003, 5'd2,  32'h0000_0000}   //  3/4 = 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] dividend = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] q_now;
    logic        out_valid;
    logic [31:0] quotient;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pow2div_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .dividend  (dividend),
        .shamt     (shamt),
        .q_now     (q_now),
        .out_valid (out_valid),
        .quotient  (quotient)
    );

    function automatic logic [31:0] ref_div(logic [31:0] x, int y);
        longint num;
        longint quo;
        num = longint'($signed(x));
        quo = num / (longint'(1) << y);
        return quo[31:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic comb_test(input logic [31:0] x, input int y, input string tag);
        logic [31:0] e;
        dividend = x;
        shamt    = 5'(y);
        #1;
        e = ref_div(x, y);
        check(q_now == e, tag, q_now, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] corners [5];
        logic [31:0] held;
        corners[0] = 32'h0000_0000;
        corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h0000_0001;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'h7FFF_FFFF;

        // R9: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
        check(quotient == 32'd0, "R9 quotient in reset", quotient, 32'd0);
        rst_n = 1'b1;

        // Vector table (R3 rounding, R4 minimum, R5 identity, R1 values)
        for (int i = 0; i < 14; i++) begin
            dividend = VECS[i].x;
            shamt    = VECS[i].y;
            #1;
            check(q_now == VECS[i].q, "R1/R3 table vector", q_now, VECS[i].q);
        end

        // Corner sweep over every legal shift (R1, R2, R4, R5)
        for (int c = 0; c < 5; c++) begin
            for (int y = 0; y <= 30; y++) begin
                comb_test(corners[c], y, "R1 corner sweep");
            end
        end
        for (int y = 0; y <= 30; y++) begin
            dividend = 32'h8000_0000;
            shamt    = 5'(y);
            #1;
            check(q_now == (32'hFFFF_FFFF << (31 - y)), "R4 min dividend", q_now,
                  32'hFFFF_FFFF << (31 - y));
        end

        // Random values (R1, R2, R6)
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rx;
            int ry;
            rx = $urandom;
            ry = int'($urandom_range(30, 0));
            comb_test(rx, ry, "R1 random");
            if (!rx[31]) begin
                check(q_now == (rx >> ry), "R2 logical shift", q_now, rx >> ry);
            end else begin
                check(q_now[31] || q_now == 0, "R6 sign of negative", q_now, ref_div(rx, ry));
            end
            if (ry == 0) check(q_now == rx, "R5 identity", q_now, rx);
        end

        // Registered wrapper: capture (R7), hold/drain (R8)
        @(negedge clk);
        dividend = 32'hFFFF_FFF9;
        shamt    = 5'd1;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 out_valid after capture", 32'(out_valid), 32'd1);
        check(quotient == 32'hFFFF_FFFD, "R7 captured quotient", quotient, 32'hFFFF_FFFD);
        dividend = 32'h0000_0040;
        shamt    = 5'd3;
        @(posedge clk);
        @(negedge clk);
        check(quotient == 32'h0000_0008, "R7 back-to-back capture", quotient, 32'h0000_0008);
        held     = quotient;
        in_valid = 1'b0;
        dividend = 32'h1234_5678;
        shamt    = 5'd0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 drain", 32'(out_valid), 32'd0);
        check(quotient == held, "R8 hold quotient", quotient, held);
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 stay empty", 32'(out_valid), 32'd0);
        check(quotient == held, "R8 hold while empty", quotient, held);

        // Reset after activity (R9)
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 reset clears valid", 32'(out_valid), 32'd0);
        check(quotient == 32'd0, "R9 reset clears quotient", quotient, 32'd0);
        in_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule